// File: doc/BRIEF.md
# Character Video RAM with ANSI Terminal Mirror

This block is a 2 KiB byte-wide character video RAM that sits on a simple CPU bus. A CPU reads and writes it like ordinary memory inside a 2048-byte window. Each write that lands in the visible 80 by 24 text area is also turned into a short byte stream for a serial ANSI terminal, so a terminal on the far side of a UART shows the same screen contents.

For each visible write, the block emits the fewest bytes it needs. It sends an attribute escape only when the reverse-video state flips. It sends a cursor positioning escape only when the write does not land directly to the right of the previous visible write. The character itself always follows. Bytes leave on a valid/ready stream. While a sequence is still draining, the block raises a stall so that the bus holds off its next write. The RAM update itself always happens in the cycle in which the write is taken.

Top module: `vram_ansi_mirror`

## Requirements
- R1: The window is selected when bus address bits [15:11] equal `base_page`, and bits [10:0] give the byte offset. A read in the window returns the stored byte on `bus_rdata` one cycle after `bus_re`. A read outside the window returns 0x00.
- R2: A write in the window that is accepted (`bus_we` high while `bus_stall` is low) stores the byte at its offset. A write outside the window changes no RAM byte and emits nothing.
- R3: An accepted write at an offset of 1920 or above updates the RAM and emits no byte.
- R4: An accepted write at an offset below 1920 has row = offset/80 + 1 and column = offset mod 80 + 1. When it is not a run continuation (R5), the stream carries 0x1B '[' row ';' column 'H'. Each number is in ASCII decimal, most significant digit first, with no leading zero.
- R5: A write is a run continuation when its row equals the last visible row and its column is one more than the last visible column. A run continuation emits only the character.
- R6: If bit 7 of the data is 1 and reverse mode is off, the stream starts with 0x1B '[' '0' '7' 'm' and reverse mode turns on.
- R7: If bit 7 of the data is 0 and reverse mode is on, the stream starts with 0x1B '[' '0' '0' 'm' and reverse mode turns off. In every other case no attribute bytes are sent.
- R8: The last byte of each sequence is the low 7 bits of the data. The value 0x7F is replaced by '#' (0x23).
- R9: After reset, `bus_stall` and `tx_valid` are low, reverse mode is off, and the last row and column are 0. The first visible write therefore always carries a positioning escape.
- R10: `bus_stall` is high from the cycle after a visible write until its last byte is taken. A write presented while the stall is high is ignored. The stored byte can be read back while the stall is still high.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value. Bytes leave in the order attribute, position, character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_page | input | 5 | Window select, compared with address bits [15:11] |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| bus_stall | output | 1 | Holds off bus writes while a sequence drains |
| tx_data | output | 8 | Terminal byte |
| tx_valid | output | 1 | Terminal byte present |
| tx_ready | input | 1 | Terminal sink takes the byte |

## Verification
The assertions assume that the bus master treats a write as not taken while `bus_stall` is high, and that `base_page` is static between resets. The bench therefore waits for the stall to drop before it counts a write as issued. Its single deliberate violation, a write held during a stall, is predicted as ignored. The sink's `tx_ready` is driven randomly, and is forced low during the stall test, so that held bytes on the stream are exercised. `base_page` is set once before reset is released.

// File: rtl/vram_mirror_pkg.sv
package vram_mirror_pkg;
  localparam int SEQ_MAX = 16;
  localparam int IDX_W   = $clog2(SEQ_MAX);
  localparam int LEN_W   = IDX_W + 1;
  localparam int POS_W   = 7;

  typedef logic [7:0] byte_t;
  localparam byte_t ESC = 8'h1B;

  // 1-based row of a screen offset
  function automatic logic [POS_W-1:0] scr_row(input int off, input int cols);
    return POS_W'(off / cols + 1);
  endfunction

  // 1-based column of a screen offset
  function automatic logic [POS_W-1:0] scr_col(input int off, input int cols);
    return POS_W'(off % cols + 1);
  endfunction

  function automatic byte_t dec_hi(input logic [POS_W-1:0] v);
    return 8'h30 + 8'(v / 7'd10);
  endfunction

  function automatic byte_t dec_lo(input logic [POS_W-1:0] v);
    return 8'h30 + 8'(v % 7'd10);
  endfunction
endpackage

// File: rtl/vram_mirror_ram.sv
module vram_mirror_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic          rhit,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= rhit ? mem[addr] : 8'h00;
  end
endmodule

// File: rtl/vram_mirror_seqgen.sv
module vram_mirror_seqgen
  import vram_mirror_pkg::*;
#(
  parameter int    COLS  = 80,
  parameter int    OFF_W = 11,
  parameter byte_t SUB   = 8'h23
) (
  input  logic [OFF_W-1:0]              off,
  input  logic [7:0]                    wdata,
  input  logic                          rev_q,
  input  logic [POS_W-1:0]              last_row,
  input  logic [POS_W-1:0]              last_col,
  output logic [SEQ_MAX-1:0][7:0]       seq,
  output logic [LEN_W-1:0]              len,
  output logic                          rev_n,
  output logic [POS_W-1:0]              row,
  output logic [POS_W-1:0]              col
);
  logic  run_cont;
  byte_t glyph;

  assign row      = scr_row(int'(off), COLS);
  assign col      = scr_col(int'(off), COLS);
  assign run_cont = (row == last_row) && (col == last_col + 7'd1);
  assign glyph    = (wdata[6:0] == 7'h7F) ? SUB : {1'b0, wdata[6:0]};

  always_comb begin
    seq   = '0;
    len   = '0;
    rev_n = rev_q;
    if (wdata[7] != rev_q) begin
      seq[0] = ESC;
      seq[1] = 8'h5B;
      seq[2] = 8'h30;
      seq[3] = wdata[7] ? 8'h37 : 8'h30;
      seq[4] = 8'h6D;
      len    = LEN_W'(5);
      rev_n  = wdata[7];
    end
    if (!run_cont) begin
      seq[len[IDX_W-1:0]] = ESC;   len = len + 1'b1;
      seq[len[IDX_W-1:0]] = 8'h5B; len = len + 1'b1;
      if (row >= 7'd10) begin
        seq[len[IDX_W-1:0]] = dec_hi(row); len = len + 1'b1;
      end
      seq[len[IDX_W-1:0]] = dec_lo(row); len = len + 1'b1;
      seq[len[IDX_W-1:0]] = 8'h3B;       len = len + 1'b1;
      if (col >= 7'd10) begin
        seq[len[IDX_W-1:0]] = dec_hi(col); len = len + 1'b1;
      end
      seq[len[IDX_W-1:0]] = dec_lo(col); len = len + 1'b1;
      seq[len[IDX_W-1:0]] = 8'h48;       len = len + 1'b1;
    end
    seq[len[IDX_W-1:0]] = glyph;
    len = len + 1'b1;
  end
endmodule

// File: rtl/vram_mirror_tx.sv
module vram_mirror_tx
  import vram_mirror_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [SEQ_MAX-1:0][7:0] seq_in,
  input  logic [LEN_W-1:0]        len_in,
  input  logic                    tx_ready,
  output logic [7:0]              tx_data,
  output logic                    tx_valid
);
  logic [SEQ_MAX-1:0][7:0] seq_q;
  logic [LEN_W-1:0]        len_q;
  logic [LEN_W-1:0]        idx_q;

  assign tx_valid = (idx_q != len_q);
  assign tx_data  = seq_q[idx_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '0;
      len_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      seq_q <= seq_in;
      len_q <= len_in;
      idx_q <= '0;
    end else if (tx_valid && tx_ready) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/vram_ansi_mirror.sv
module vram_ansi_mirror
  import vram_mirror_pkg::*;
#(
  parameter int    ADDR_W    = 16,
  parameter int    MEM_BYTES = 2048,
  parameter int    COLS      = 80,
  parameter int    ROWS      = 24,
  parameter byte_t BLOCK_SUB = 8'h23,
  localparam int   OFF_W     = $clog2(MEM_BYTES),
  localparam int   PAGE_W    = ADDR_W - OFF_W,
  localparam int   VIS_BYTES = COLS * ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] base_page,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              bus_stall,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);
  logic [OFF_W-1:0]        off;
  logic                    hit, vis, acc_wr, acc_vis, acc_hid;
  logic                    rev_q, rev_n;
  logic [POS_W-1:0]        last_row, last_col, row, col;
  logic [SEQ_MAX-1:0][7:0] seq;
  logic [LEN_W-1:0]        seq_len;

  assign off       = bus_addr[OFF_W-1:0];
  assign hit       = (bus_addr[ADDR_W-1:OFF_W] == base_page);
  assign vis       = (int'(off) < VIS_BYTES);
  assign bus_stall = tx_valid;
  assign acc_wr    = bus_we && hit && !bus_stall;
  assign acc_vis   = acc_wr && vis;
  assign acc_hid   = acc_wr && !vis;

  vram_mirror_ram #(.DEPTH(MEM_BYTES)) ram_i (
    .clk(clk), .rst_n(rst_n), .we(acc_wr), .addr(off), .wdata(bus_wdata),
    .re(bus_re), .rhit(hit), .rdata(bus_rdata)
  );

  vram_mirror_seqgen #(.COLS(COLS), .OFF_W(OFF_W), .SUB(BLOCK_SUB)) gen_i (
    .off(off), .wdata(bus_wdata), .rev_q(rev_q), .last_row(last_row),
    .last_col(last_col), .seq(seq), .len(seq_len), .rev_n(rev_n),
    .row(row), .col(col)
  );

  vram_mirror_tx tx_i (
    .clk(clk), .rst_n(rst_n), .load(acc_vis), .seq_in(seq), .len_in(seq_len),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rev_q    <= 1'b0;
      last_row <= '0;
      last_col <= '0;
    end else if (acc_vis) begin
      rev_q    <= rev_n;
      last_row <= row;
      last_col <= col;
    end
  end
endmodule

// File: rtl/vram_ansi_mirror_chk.sv
module vram_ansi_mirror_chk #(
  parameter int COLS = 80,
  parameter int ROWS = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_vis,
  input logic       acc_hid,
  input logic       rev_q,
  input logic [6:0] last_row,
  input logic [6:0] last_col,
  input logic       bus_stall,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready
);
  // R3
  hidden_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hid |=> !tx_valid);
  // R10
  visible_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vis |=> (tx_valid && bus_stall));
  // R11
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R6
  rev_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vis |=> $stable(rev_q));
  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(last_col) <= COLS) && (int'(last_row) <= ROWS));
endmodule

bind vram_ansi_mirror vram_ansi_mirror_chk #(.COLS(COLS), .ROWS(ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_vis(acc_vis), .acc_hid(acc_hid),
  .rev_q(rev_q), .last_row(last_row), .last_col(last_col),
  .bus_stall(bus_stall), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready)
);

// File: tb/vram_ansi_mirror_tb.sv
module vram_ansi_mirror_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PAGE = 5'd26;
  localparam logic [15:0] BASE = {PAGE, 11'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  base_page = PAGE;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata, tx_data;
  logic bus_we = 1'b0, bus_re = 1'b0, bus_stall, tx_valid, tx_ready = 1'b1;
  bit   hold_ready = 1'b0, rand_ready = 1'b0;

  int checks = 0, errors = 0;
  bit [7:0] exp_q[$];
  bit [7:0] shadow [2048];
  bit m_rev = 1'b0;
  int m_row = 0, m_col = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_ansi_mirror dut_i (
    .clk(clk), .rst_n(rst_n), .base_page(base_page), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_stall(bus_stall), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic void push_str(input string s);
    for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
  endfunction

  // bench view of R1..R8
  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    int off, r, c;
    if (a[15:11] != PAGE) return;
    off = int'(a[10:0]);
    shadow[off] = d;
    if (off >= 1920) return;
    r = off / 80 + 1;
    c = off % 80 + 1;
    if (d[7] && !m_rev) begin push_str("\033[07m"); m_rev = 1'b1; end
    else if (!d[7] && m_rev) begin push_str("\033[00m"); m_rev = 1'b0; end
    if (!(r == m_row && c == m_col + 1)) push_str($sformatf("\033[%0d;%0dH", r, c));
    exp_q.push_back((d[6:0] == 7'h7F) ? 8'h23 : {1'b0, d[6:0]});
    m_row = r;
    m_col = c;
  endfunction

  // R4 R5 R6 R7 R8 R11: every byte taken is compared in order
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", tx_data, 0);
      else check(tx_data == exp_q.pop_front(), "R4/stream byte", tx_data, 0);
    end
  end

  always @(negedge clk) begin
    if (hold_ready) tx_ready = 1'b0;
    else if (rand_ready) tx_ready = ($urandom % 3) != 0;
    else tx_ready = 1'b1;
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    while (bus_stall) @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    model_write(a, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic drain();
    while (bus_stall) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R4 missing bytes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!bus_stall, "R9 stall", bus_stall, 0);
    check(!tx_valid, "R9 valid", tx_valid, 0);
    // R9 R4 first write is absolute
    wr(BASE + 16'd0, "A");
    // R5 run continuation
    wr(BASE + 16'd1, "B");
    drain();
    wr(BASE + 16'd79, "C");
    wr(BASE + 16'd80, "D");   // R4 wrap to row 2
    // R6 reverse on, R7 off
    wr(BASE + 16'd81, 8'hC5);
    wr(BASE + 16'd82, 8'hC6);
    wr(BASE + 16'd83, "G");
    // R8 block glyph with and without reverse
    wr(BASE + 16'd84, 8'h7F);
    wr(BASE + 16'd85, 8'hFF);
    wr(BASE + 16'd1919, "Z"); // last visible
    drain();
    // R3 hidden offsets
    wr(BASE + 16'd1920, 8'h5A);
    wr(BASE + 16'd2047, 8'hA5);
    @(negedge clk);
    check(!tx_valid, "R3 no stream", tx_valid, 0);
    rd(BASE + 16'd1920, 8'h5A, "R3 readback");
    rd(BASE + 16'd2047, 8'hA5, "R3 readback");
    // R2 outside window
    wr(16'hC800 + 16'd5, 8'h11);
    @(negedge clk);
    check(!tx_valid, "R2 outside silent", tx_valid, 0);
    rd(BASE + 16'd5, shadow[5], "R2 outside untouched");
    rd(16'hC800 + 16'd5, 8'h00, "R1 outside read");
    // R10 stall behaviour
    hold_ready = 1'b1;
    wr(BASE + 16'd300, "Q");
    check(bus_stall, "R10 stall high", bus_stall, 1);
    rd(BASE + 16'd300, "Q", "R10 readback during stall");
    bus_addr = BASE + 16'd301; bus_wdata = "X"; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(BASE + 16'd301, shadow[301], "R10 stalled write ignored");
    check(tx_valid, "R11 held valid", tx_valid, 1);
    hold_ready = 1'b0;
    drain();
    // random traffic
    rand_ready = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int k = $urandom % 10;
      if (k == 0) a = 16'(($urandom % 2048) + 16'h4000);
      else if (k < 4 && m_row > 0 && m_col < 80)
        a = BASE + 16'((m_row - 1) * 80 + m_col);
      else a = BASE + 16'($urandom % 2048);
      wr(a, 8'($urandom));
    end
    drain();
    for (int i = 0; i < 100; i++) begin
      int o = $urandom % 2048;
      rd(BASE + 16'(o), shadow[o], "R1 random readback");
    end
    finish_run();
  end
endmodule